// File: doc/BRIEF.md
# Processor Countdown Timer

This block is the per-core interval timer that sits beside an interrupt controller. Software programs three values through a small register port: a timer entry (interrupt vector, a mask flag and a repeat flag), a divide code that sets how many clocks make one count step, and a starting count. Writing the starting count loads the down-counter and restarts the divider, so counting always begins at that write.

In single-shot mode the count steps down to zero, raises one expiry and then rests at zero. In repeating mode the count reloads the starting value on the step after it reaches zero, so each period lasts the starting count plus one steps, with one expiry per reload. An expiry shows up as a one-cycle pulse with the entry's vector beside it, unless the entry is masked. Routing of that vector to a core, and address decoding on a system bus, belong to the surrounding logic.

Top module: `cpu_countdown_timer`

## Requirements
- R1: A write to the divide register (select 3) stores only data bits 3, 1 and 0. Readback returns those bits in the same positions, with all other bits zero.
- R2: With divide code c = {bit3, bit1, bit0}, the exponent is (c + 1) mod 8 and the count drops by one every 2^exponent clocks. Code 7 (0xB) divides by 1, code 0 by 2, code 3 by 16 and code 4 (0x8) by 32.
- R3: A write of N to the starting-count register (select 1) sets the current count to N on that clock edge and restarts the divider. The first step lands 2^exponent edges after the write, and any earlier countdown is abandoned.
- R4: In single-shot mode (entry bit 17 clear) the count reaches zero at edge W + N*2^exponent, gives one expiry at that edge and then holds at zero.
- R5: In repeating mode (entry bit 17 set) the count reloads N on the step after it reaches zero. Expiries fall at edges W + m*(N+1)*2^exponent for m = 1, 2, ...
- R6: An expiry drives irq_valid high for one cycle, registered on the expiry edge, with irq_vector equal to entry bits 7:0. No pulse appears when entry bit 16 (mask) is set.
- R7: The timer entry sits at select 0. Readback gives the vector in bits 7:0, mask in bit 16 and repeat in bit 17, and zero in all other bits.
- R8: A starting count of zero leaves the timer idle. The current count reads zero and no expiry follows, in either mode.
- R9: Rewriting the timer entry changes mode, mask and vector without altering the current count. A repeating timer switched to single-shot expires once when it next reaches zero.
- R10: After reset the entry reads 0x0001_0000 (masked), and the starting count, current count and divide register read zero. irq_valid is low.
- R11: A read with rd_en high returns the selected register on rd_data in the following cycle. Select 2 returns the current count, and writes to select 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 entry, 1 starting count, 2 current count (ignored), 3 divide |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read select, same encoding as wr_addr |
| rd_data | output | CNT_W | Read data, valid the cycle after rd_en |
| irq_valid | output | 1 | One-cycle expiry pulse |
| irq_vector | output | VEC_W | Vector that goes with irq_valid |

## Verification
The properties assume that a write strobe selects a single register per cycle and that the divide code changes only while the timer is idle or just before a fresh starting count. Under those conditions the step grid set by the divider stays aligned with the load edge. The stimulus always writes the divide code and the entry before the starting count, and it changes the entry or the starting count during a countdown only at edges that lie away from a reload. As a result, every expected expiry edge can be computed exactly from the load edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // divide code is {bit3, bit1, bit0} of the divide register
  localparam int DIV_CODE_W = 3;
  // entry flag positions
  localparam int MASK_POS     = 16;
  localparam int PERIODIC_POS = 17;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_START = 2'd1,
    SEL_CURR  = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  // exponent wraps modulo 8, so code 7 gives divide by one
  function automatic logic [DIV_CODE_W-1:0] code_to_exp(input logic [DIV_CODE_W-1:0] code);
    return code + DIV_CODE_W'(1);
  endfunction

endpackage

// File: rtl/cdt_regfile.sv
module cdt_regfile
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [VEC_W-1:0]      vec_q,
  output logic                  mask_q,
  output logic                  periodic_q,
  output logic [CNT_W-1:0]      start_q,
  output logic [DIV_CODE_W-1:0] div_code_q,
  output logic [DIV_CODE_W-1:0] exp_val,
  output logic                  load,
  output logic [CNT_W-1:0]      load_val
);

  always_comb begin
    load     = wr_en && (wr_addr == SEL_START);
    load_val = wr_data;
    exp_val  = code_to_exp(div_code_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      periodic_q <= 1'b0;
      start_q    <= '0;
      div_code_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_ENTRY: begin
          vec_q      <= wr_data[VEC_W-1:0];
          mask_q     <= wr_data[MASK_POS];
          periodic_q <= wr_data[PERIODIC_POS];
        end
        SEL_START: start_q <= wr_data;
        SEL_DIV:   div_code_q <= {wr_data[3], wr_data[1:0]};
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_val,
  output logic             tick
);

  localparam int PW = (1 << EXP_W) - 1;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] sel_mask;

  // a step happens when every selected low bit of the free counter is one
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      sel_mask[i] = (i < int'(exp_val));
    end
    tick = &(pcnt | ~sel_mask);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + PW'(1);
    end
  end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cur,
  output logic             armed,
  output logic             expire
);

  logic at_zero;
  logic at_one;

  always_comb begin
    at_zero = (cur == '0);
    at_one  = (cur == CNT_W'(1));
    expire  = armed && tick && !load && (periodic ? at_zero : at_one);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cur   <= load_val;
      armed <= (load_val != '0);
    end else if (armed && tick) begin
      if (at_zero) begin
        if (periodic) begin
          cur <= reload_val;
        end else begin
          armed <= 1'b0;
        end
      end else begin
        cur <= cur - CNT_W'(1);
        if (at_one && !periodic) begin
          armed <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/cpu_countdown_timer.sv
module cpu_countdown_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);

  logic [VEC_W-1:0]      vec_q;
  logic                  mask_q;
  logic                  periodic_q;
  logic [CNT_W-1:0]      start_q;
  logic [DIV_CODE_W-1:0] div_code_q;
  logic [DIV_CODE_W-1:0] exp_val;
  logic                  load;
  logic [CNT_W-1:0]      load_val;
  logic                  tick;
  logic [CNT_W-1:0]      cur;
  logic                  armed;
  logic                  expire;
  logic [CNT_W-1:0]      rd_mux;

  cdt_regfile #(.CNT_W(CNT_W), .VEC_W(VEC_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .vec_q      (vec_q),
    .mask_q     (mask_q),
    .periodic_q (periodic_q),
    .start_q    (start_q),
    .div_code_q (div_code_q),
    .exp_val    (exp_val),
    .load       (load),
    .load_val   (load_val)
  );

  cdt_prescaler #(.EXP_W(DIV_CODE_W)) presc_i (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .exp_val (exp_val),
    .tick    (tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_val   (load_val),
    .reload_val (start_q),
    .periodic   (periodic_q),
    .tick       (tick),
    .cur        (cur),
    .armed      (armed),
    .expire     (expire)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_sel_e'(rd_addr))
      SEL_ENTRY: begin
        rd_mux[VEC_W-1:0]   = vec_q;
        rd_mux[MASK_POS]     = mask_q;
        rd_mux[PERIODIC_POS] = periodic_q;
      end
      SEL_START: rd_mux = start_q;
      SEL_CURR:  rd_mux = cur;
      SEL_DIV: begin
        rd_mux[3]   = div_code_q[2];
        rd_mux[1:0] = div_code_q[1:0];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      if (rd_en) begin
        rd_data <= rd_mux;
      end
      irq_valid <= expire && !mask_q;
      if (expire) begin
        irq_vector <= vec_q;
      end
    end
  end

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_valid,
  input logic             mask_q,
  input logic             periodic_q,
  input logic             armed,
  input logic             tick,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] start_q
);

  // R6
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(mask_q));

  // R2
  step_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !load && !tick) |=> (cur == $past(cur)));

  // R4
  oneshot_end_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !periodic_q && tick && !load && cur == CNT_W'(1)) |=> (cur == '0 && !armed));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && cur == '0 && !load) |=> (cur == '0 && !irq_valid));

  // R5
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && periodic_q && tick && !load && cur == '0) |=>
      (cur == $past(start_q) && irq_valid == !$past(mask_q)));

  // R8
  zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> (!armed && cur == '0));

endmodule

bind cpu_countdown_timer cdt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .irq_valid  (irq_valid),
  .mask_q     (mask_q),
  .periodic_q (periodic_q),
  .armed      (armed),
  .tick       (tick),
  .load       (load),
  .load_val   (load_val),
  .cur        (cur),
  .start_q    (start_q)
);

// File: tb/cpu_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module cpu_countdown_timer_tb_top;

  localparam int CNT_W = 32;
  localparam int VEC_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [1:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             irq_valid;
  logic [VEC_W-1:0] irq_vector;

  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  typedef struct {
    int unsigned edge_no;
    logic [7:0]  vec;
    string       tag;
  } fire_t;

  fire_t fq[$];

  cpu_countdown_timer #(.CNT_W(CNT_W), .VEC_W(VEC_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected expiries and compares edge and vector
  always @(negedge clk) begin
    if (!rst && !done) begin
      while (fq.size() > 0 && fq[0].edge_no < cyc) begin
        n_chk++; n_bad++;
        $display("FAIL %s: no expiry at edge %0d (actual none, expected vector %h)",
                 fq[0].tag, fq[0].edge_no, fq[0].vec);
        void'(fq.pop_front());
      end
      if (irq_valid) begin
        n_chk++;
        if (fq.size() == 0 || fq[0].edge_no != cyc) begin
          n_bad++;
          $display("FAIL R6: unexpected expiry at edge %0d (actual vector %h, expected none)",
                   cyc, irq_vector);
        end else begin
          if (irq_vector !== fq[0].vec) begin
            n_bad++;
            $display("FAIL %s: vector at edge %0d actual %h expected %h",
                     fq[0].tag, cyc, irq_vector, fq[0].vec);
          end
          void'(fq.pop_front());
        end
      end
    end
  end

  task automatic push_fire(input int unsigned e, input logic [7:0] v, input string tag);
    fire_t f;
    f.edge_no = e; f.vec = v; f.tag = tag;
    fq.push_back(f);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int unsigned w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    w = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    n_chk++;
    if (rd_data !== expv) begin
      n_bad++;
      $display("FAIL %s: select %0d actual %h expected %h", tag, a, rd_data, expv);
    end
  endtask

  function automatic int unsigned cnt_model(input int unsigned w, input int unsigned n,
                                            input int unsigned e, input bit per,
                                            input int unsigned t);
    int unsigned k;
    k = (t - w) >> e;
    if (per) return n - (k % (n + 1));
    return (k >= n) ? 0 : n - k;
  endfunction

  task automatic rd_cnt(input int unsigned w, input int unsigned n, input int unsigned e,
                        input bit per, input string tag);
    int unsigned r;
    int unsigned expv;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd2;
    r = cyc + 1;
    @(negedge clk);
    rd_en = 1'b0;
    expv = cnt_model(w, n, e, per, r - 1);
    n_chk++;
    if (rd_data !== expv) begin
      n_bad++;
      $display("FAIL %s: current count actual %0d expected %0d", tag, rd_data, expv);
    end
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    finish_run();
  end

  initial begin
    int unsigned w, w2, u, lim;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd_chk(2'd0, 32'h0001_0000, "R10");
    rd_chk(2'd1, 32'h0, "R10");
    rd_chk(2'd2, 32'h0, "R10");
    rd_chk(2'd3, 32'h0, "R10");

    // R4 R6 R7 single-shot, divide by one (code 0xB)
    wr(2'd3, 32'h0000_000B, w);
    wr(2'd0, 32'h0000_0041, w);
    rd_chk(2'd0, 32'h0000_0041, "R7");
    wr(2'd1, 32'd5, w);
    push_fire(w + 5, 8'h41, "R4");
    rd_cnt(w, 5, 0, 1'b0, "R11");
    wait_until(w + 20);
    rd_cnt(w, 5, 0, 1'b0, "R4");

    // R1 divide register keeps bits 3,1,0
    wr(2'd3, 32'hFFFF_FFFF, w);
    rd_chk(2'd3, 32'h0000_000B, "R1");
    wr(2'd3, 32'h0000_0004, w);
    rd_chk(2'd3, 32'h0000_0000, "R1");

    // R2 code 0 divides by 2
    wr(2'd0, 32'h0000_0042, w);
    wr(2'd1, 32'd3, w);
    push_fire(w + 6, 8'h42, "R2");
    rd_cnt(w, 3, 1, 1'b0, "R2");
    wait_until(w + 12);

    // R2 code 3 divides by 16
    wr(2'd3, 32'h0000_0003, w);
    wr(2'd1, 32'd2, w);
    push_fire(w + 32, 8'h42, "R2");
    wait_until(w + 20);
    rd_cnt(w, 2, 4, 1'b0, "R2");
    wait_until(w + 40);

    // R2 code 4 (0x8) divides by 32
    wr(2'd3, 32'h0000_0008, w);
    wr(2'd1, 32'd2, w);
    push_fire(w + 64, 8'h42, "R2");
    wait_until(w + 40);
    rd_cnt(w, 2, 5, 1'b0, "R2");
    wait_until(w + 70);

    // R5 repeating mode, period N+1
    wr(2'd3, 32'h0000_000B, w);
    wr(2'd0, 32'h0002_0077, w);
    wr(2'd1, 32'd3, w);
    push_fire(w + 4, 8'h77, "R5");
    push_fire(w + 8, 8'h77, "R5");
    push_fire(w + 12, 8'h77, "R5");
    rd_cnt(w, 3, 0, 1'b1, "R5");
    wait_until(w + 12);
    wr(2'd1, 32'd0, w2);
    // R8 idle after zero start
    rd_chk(2'd2, 32'h0, "R8");
    wait_until(w2 + 20);
    // R11 write to current count select has no effect
    wr(2'd2, 32'h0000_0055, w);
    rd_chk(2'd2, 32'h0, "R11");

    // R6 R9 masked repeating timer, then unmask by rewriting the entry
    wr(2'd0, 32'h0003_005A, w);
    wr(2'd1, 32'd2, w);
    wait_until(w + 10);
    rd_cnt(w, 2, 0, 1'b1, "R6");
    wr(2'd0, 32'h0002_005A, u);
    lim = w + 3;
    while (lim <= u) lim += 3;
    push_fire(lim, 8'h5A, "R6");
    push_fire(lim + 3, 8'h5A, "R6");
    push_fire(lim + 6, 8'h5A, "R6");
    rd_cnt(w, 2, 0, 1'b1, "R9");
    wait_until(lim + 6);
    wr(2'd1, 32'd0, w2);

    // R9 repeating switched to single-shot mid-count
    wr(2'd0, 32'h0002_0033, w);
    wr(2'd1, 32'd6, w);
    wr(2'd0, 32'h0000_0033, u);
    push_fire(w + 6, 8'h33, "R9");
    rd_cnt(w, 6, 0, 1'b0, "R9");
    wait_until(w + 30);
    rd_cnt(w, 6, 0, 1'b0, "R9");

    // R3 rewriting the starting count restarts the countdown
    wr(2'd0, 32'h0000_0021, w);
    wr(2'd1, 32'd10, w);
    wait_until(w + 4);
    wr(2'd1, 32'd3, w2);
    push_fire(w2 + 3, 8'h21, "R3");
    rd_cnt(w2, 3, 0, 1'b0, "R3");
    wait_until(w2 + 20);

    // R8 single-shot with zero start
    wr(2'd1, 32'd0, w);
    wait_until(w + 15);
    rd_chk(2'd2, 32'h0, "R8");
    rd_chk(2'd1, 32'h0, "R8");

    repeat (5) @(negedge clk);
    n_chk++;
    if (fq.size() != 0) begin
      n_bad++;
      $display("FAIL R5: %0d expiries outstanding (actual %0d, expected 0)", fq.size(), fq.size());
    end
    finish_run();
  end

endmodule